// File: doc/BRIEF.md
# PWM Output Steering Stage

This block sits between a PWM duty generator and the two pin drivers of one PWM channel. It takes the generator's raw high-side waveform, plus a second raw waveform used only in independent operation, and produces a registered high pin drive, a registered low pin drive and an ownership flag for each pin. A two-bit mode field picks complementary, independent or push-pull operation. In complementary operation a programmable dead-time count keeps both sides inactive after every change of level. An active override can replace the raw source. In complementary operation a force-on option lets the override bypass dead time. Swap and per-pin polarity are applied after the mode logic.

Configuration is loaded through a write strobe. While the generator's run input is high, the mode, pin-enable and polarity fields hold their values and ignore writes. The swap, force-on and dead-time fields can be written at any time. A one-cycle period marker from the duty generator drives the push-pull alternation.

Top module: `pwm_out_steer`

## Requirements
- R1: The mode field encodes 00 complementary, 01 independent, 10 push-pull and 11 reserved. Pin outputs are registered: a pin shows the result of the inputs and configuration present one clock edge earlier.
- R2: In complementary mode the logical low side is the inverse of the logical high side. When the target level changes, both logical sides are inactive for exactly the dead-time count of cycles before the new level appears. A count of 0 gives no gap. A further change during the gap restarts it.
- R3: In independent mode the logical high side follows `raw_hi` and the logical low side follows `raw_lo`.
- R4: In push-pull mode, each `period_start` pulse moves the steering to the other side, and the pulse takes effect in its own cycle. The first period after reset goes to the high side. The selected side carries `raw_hi` and the other side is inactive.
- R5: The reserved mode holds both logical sides inactive, with or without an override.
- R6: With `ovr_en` high, `ovr_hi` replaces the high-side source. In independent and push-pull modes, `ovr_lo` drives the low side. In complementary mode the low side is the inverse of `ovr_hi`.
- R7: In complementary mode with force-on set, an override level appears at the next edge with no dead-time gap and cancels any gap in progress. With force-on clear, the override level passes through the dead-time gap.
- R8: With swap set, the logical high side drives `pin_lo` and the logical low side drives `pin_hi`.
- R9: Each pin is inverted when its polarity bit is 1 (active-low). Inversion is applied after swap, so the pin polarity stays with the pin.
- R10: `own_hi` and `own_lo` equal the stored pin-enable bits. They update on the edge that accepts a write.
- R11: While `gen_on` is high, a write leaves the mode, enable and polarity fields unchanged, but it still updates swap, force-on and dead time.
- R12: After reset all configuration fields are 0, both pins and both ownership flags are 0, and the push-pull selector is set so that the first period goes to the high side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_on | input | 1 | Generator running; locks the mode, enable and polarity fields |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode: 00 complementary, 01 independent, 10 push-pull, 11 reserved |
| cfg_swap | input | 1 | Exchange high and low sides at the pins |
| cfg_force_on | input | 1 | Override bypasses dead time (complementary mode only) |
| cfg_en_hi | input | 1 | High pin owned by the generator |
| cfg_en_lo | input | 1 | Low pin owned by the generator |
| cfg_inv_hi | input | 1 | High pin active-low |
| cfg_inv_lo | input | 1 | Low pin active-low |
| cfg_dead | input | DT_W | Dead-time count in clock cycles |
| raw_hi | input | 1 | Raw high-side PWM waveform |
| raw_lo | input | 1 | Raw low-side waveform (independent mode) |
| period_start | input | 1 | One-cycle pulse at the start of each PWM period |
| ovr_en | input | 1 | Active override enable |
| ovr_hi | input | 1 | Override level for the high side |
| ovr_lo | input | 1 | Override level for the low side |
| pin_hi | output | 1 | High pin drive |
| pin_lo | output | 1 | Low pin drive |
| own_hi | output | 1 | High pin ownership flag |
| own_lo | output | 1 | Low pin ownership flag |

## Verification
A wrong dead-time counter shows at the next edge after a level change. Both pins then either stay inactive for the wrong number of cycles or show the new level too early. A checker also flags any cycle in which the counter is running while a pin is active. A wrong push-pull selector sends a pulse to the wrong pin on the first period after reset, and that error persists until the next period marker. A lock fault shows one edge after a write made while the generator runs, as a change in an ownership flag or in the pin polarity.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

    typedef enum logic [1:0] {
        MODE_COMP = 2'b00,
        MODE_IND  = 2'b01,
        MODE_PP   = 2'b10,
        MODE_RSV  = 2'b11
    } steer_mode_e;

    typedef struct packed {
        steer_mode_e mode;
        logic        swap;
        logic        force_on;
        logic        en_hi;
        logic        en_lo;
        logic        inv_hi;
        logic        inv_lo;
    } steer_flags_t;

    localparam int NUM_PINS = 2;

endpackage

// File: rtl/pwm_steer_cfg.sv
module pwm_steer_cfg
    import pwm_steer_pkg::*;
#(
    parameter int DT_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gen_on,
    input  logic               wr_en,
    input  steer_flags_t       wr_flags,
    input  logic [DT_W-1:0]    wr_dead,
    output steer_flags_t       flags_q,
    output logic [DT_W-1:0]    dead_q
);

    typedef struct packed {
        steer_flags_t    f;
        logic [DT_W-1:0] dead;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Next-state: swap, force-on and dead time always load; the
    // pin-shaping fields load only while the generator is stopped.
    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.f.swap     = wr_flags.swap;
            cfg_d.f.force_on = wr_flags.force_on;
            cfg_d.dead       = wr_dead;
            if (!gen_on) begin
                cfg_d.f.mode   = wr_flags.mode;
                cfg_d.f.en_hi  = wr_flags.en_hi;
                cfg_d.f.en_lo  = wr_flags.en_lo;
                cfg_d.f.inv_hi = wr_flags.inv_hi;
                cfg_d.f.inv_lo = wr_flags.inv_lo;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign flags_q = cfg_q.f;
    assign dead_q  = cfg_q.dead;

endmodule

// File: rtl/pwm_steer_core.sv
module pwm_steer_core
    import pwm_steer_pkg::*;
#(
    parameter int DT_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  steer_mode_e     mode,
    input  logic            force_on,
    input  logic [DT_W-1:0] dead,
    input  logic            raw_hi,
    input  logic            raw_lo,
    input  logic            period_start,
    input  logic            ovr_en,
    input  logic            ovr_hi,
    input  logic            ovr_lo,
    output logic            side_hi_d,
    output logic            side_lo_d,
    output logic            dt_busy
);

    typedef struct packed {
        logic            lvl;   // committed complementary level
        logic            sel;   // push-pull side: 0 high, 1 low
        logic [DT_W-1:0] dt;    // remaining gap cycles
    } core_st_t;

    localparam core_st_t ST_RESET = '{lvl: 1'b0, sel: 1'b1, dt: '0};

    core_st_t st_d, st_q;
    logic     tgt;

    always_comb begin
        st_d      = st_q;
        side_hi_d = 1'b0;
        side_lo_d = 1'b0;
        tgt       = ovr_en ? ovr_hi : raw_hi;

        if (period_start) begin
            st_d.sel = ~st_q.sel;
        end

        case (mode)
            MODE_COMP: begin
                if (ovr_en && force_on) begin
                    st_d.lvl = tgt;
                    st_d.dt  = '0;
                end else if (tgt != st_q.lvl) begin
                    st_d.lvl = tgt;
                    st_d.dt  = dead;
                end else if (st_q.dt != '0) begin
                    st_d.dt  = st_q.dt - DT_W'(1);
                end
                if (st_d.dt == '0) begin
                    side_hi_d = st_d.lvl;
                    side_lo_d = ~st_d.lvl;
                end
            end
            MODE_IND: begin
                st_d.lvl  = tgt;
                st_d.dt   = '0;
                side_hi_d = tgt;
                side_lo_d = ovr_en ? ovr_lo : raw_lo;
            end
            MODE_PP: begin
                st_d.lvl = tgt;
                st_d.dt  = '0;
                if (ovr_en) begin
                    side_hi_d = ovr_hi;
                    side_lo_d = ovr_lo;
                end else begin
                    side_hi_d = raw_hi & ~st_d.sel;
                    side_lo_d = raw_hi &  st_d.sel;
                end
            end
            MODE_RSV: begin
                st_d.lvl = tgt;
                st_d.dt  = '0;
            end
            default: begin
                st_d.dt  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign dt_busy = (st_q.dt != '0);

endmodule

// File: rtl/pwm_steer_pinmap.sv
module pwm_steer_pinmap
    import pwm_steer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic swap,
    input  logic inv_hi,
    input  logic inv_lo,
    input  logic side_hi,
    input  logic side_lo,
    output logic pin_hi,
    output logic pin_lo
);

    logic [NUM_PINS-1:0] side_v, inv_v, pin_d, pin_q;

    assign side_v = {side_lo, side_hi};
    assign inv_v  = {inv_lo, inv_hi};

    // Index 0 is the high pin, index 1 the low pin. Swap picks the
    // opposite side; polarity belongs to the pin and is applied last.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign pin_d[i] = (swap ? side_v[NUM_PINS-1-i] : side_v[i]) ^ inv_v[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '0;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign pin_hi = pin_q[0];
    assign pin_lo = pin_q[1];

endmodule

// File: rtl/pwm_out_steer.sv
module pwm_out_steer
    import pwm_steer_pkg::*;
#(
    parameter int DT_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gen_on,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_mode,
    input  logic            cfg_swap,
    input  logic            cfg_force_on,
    input  logic            cfg_en_hi,
    input  logic            cfg_en_lo,
    input  logic            cfg_inv_hi,
    input  logic            cfg_inv_lo,
    input  logic [DT_W-1:0] cfg_dead,
    input  logic            raw_hi,
    input  logic            raw_lo,
    input  logic            period_start,
    input  logic            ovr_en,
    input  logic            ovr_hi,
    input  logic            ovr_lo,
    output logic            pin_hi,
    output logic            pin_lo,
    output logic            own_hi,
    output logic            own_lo
);

    steer_flags_t    wr_flags;
    steer_flags_t    flags_q;
    logic [DT_W-1:0] dead_q;
    logic            side_hi_d, side_lo_d;
    logic            dt_busy;
    logic [1:0]      cur_mode;
    logic            cur_inv_hi, cur_inv_lo;

    always_comb begin
        wr_flags          = '0;
        wr_flags.mode     = steer_mode_e'(cfg_mode);
        wr_flags.swap     = cfg_swap;
        wr_flags.force_on = cfg_force_on;
        wr_flags.en_hi    = cfg_en_hi;
        wr_flags.en_lo    = cfg_en_lo;
        wr_flags.inv_hi   = cfg_inv_hi;
        wr_flags.inv_lo   = cfg_inv_lo;
    end

    pwm_steer_cfg #(.DT_W(DT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .gen_on   (gen_on),
        .wr_en    (cfg_we),
        .wr_flags (wr_flags),
        .wr_dead  (cfg_dead),
        .flags_q  (flags_q),
        .dead_q   (dead_q)
    );

    pwm_steer_core #(.DT_W(DT_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (flags_q.mode),
        .force_on     (flags_q.force_on),
        .dead         (dead_q),
        .raw_hi       (raw_hi),
        .raw_lo       (raw_lo),
        .period_start (period_start),
        .ovr_en       (ovr_en),
        .ovr_hi       (ovr_hi),
        .ovr_lo       (ovr_lo),
        .side_hi_d    (side_hi_d),
        .side_lo_d    (side_lo_d),
        .dt_busy      (dt_busy)
    );

    pwm_steer_pinmap u_pinmap (
        .clk     (clk),
        .rst_n   (rst_n),
        .swap    (flags_q.swap),
        .inv_hi  (flags_q.inv_hi),
        .inv_lo  (flags_q.inv_lo),
        .side_hi (side_hi_d),
        .side_lo (side_lo_d),
        .pin_hi  (pin_hi),
        .pin_lo  (pin_lo)
    );

    assign own_hi     = flags_q.en_hi;
    assign own_lo     = flags_q.en_lo;
    assign cur_mode   = flags_q.mode;
    assign cur_inv_hi = flags_q.inv_hi;
    assign cur_inv_lo = flags_q.inv_lo;

endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       gen_on,
    input logic [1:0] mode,
    input logic       inv_hi,
    input logic       inv_lo,
    input logic       ovr_en,
    input logic       dt_busy,
    input logic       pin_hi,
    input logic       pin_lo,
    input logic       own_hi,
    input logic       own_lo
);

    // R11: locked fields do not move while the generator runs
    p_lock_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        gen_on |=> ($stable(own_hi) && $stable(own_lo) && $stable(mode)
                    && $stable(inv_hi) && $stable(inv_lo)));

    // R2: complementary sides never active together
    p_comp_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b00) |->
            !((pin_hi ^ $past(inv_hi)) && (pin_lo ^ $past(inv_lo))));

    // R2: a running gap holds both pins at their inactive levels
    p_gap_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dt_busy |-> ((pin_hi == $past(inv_hi)) && (pin_lo == $past(inv_lo))));

    // R5: reserved mode drives nothing active
    p_rsv_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b11) |->
            ((pin_hi == $past(inv_hi)) && (pin_lo == $past(inv_lo))));

    // R4: push-pull without override uses one side at a time
    p_pp_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mode) == 2'b10) && !$past(ovr_en)) |->
            !((pin_hi ^ $past(inv_hi)) && (pin_lo ^ $past(inv_lo))));

endmodule

bind pwm_out_steer pwm_steer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .gen_on  (gen_on),
    .mode    (cur_mode),
    .inv_hi  (cur_inv_hi),
    .inv_lo  (cur_inv_lo),
    .ovr_en  (ovr_en),
    .dt_busy (dt_busy),
    .pin_hi  (pin_hi),
    .pin_lo  (pin_lo),
    .own_hi  (own_hi),
    .own_lo  (own_lo)
);

// File: tb/pwm_out_steer_bench.sv
module pwm_out_steer_bench;

    localparam int DT_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gen_on = 0, cfg_we = 0, cfg_swap = 0, cfg_force_on = 0;
    logic cfg_en_hi = 0, cfg_en_lo = 0, cfg_inv_hi = 0, cfg_inv_lo = 0;
    logic [1:0] cfg_mode = 2'b00;
    logic [DT_W-1:0] cfg_dead = '0;
    logic raw_hi = 0, raw_lo = 0, period_start = 0;
    logic ovr_en = 0, ovr_hi = 0, ovr_lo = 0;
    logic pin_hi, pin_lo, own_hi, own_lo;

    pwm_out_steer #(.DT_W(DT_W)) u_pwm_out_steer (
        .clk(clk), .rst_n(rst_n), .gen_on(gen_on), .cfg_we(cfg_we),
        .cfg_mode(cfg_mode), .cfg_swap(cfg_swap), .cfg_force_on(cfg_force_on),
        .cfg_en_hi(cfg_en_hi), .cfg_en_lo(cfg_en_lo),
        .cfg_inv_hi(cfg_inv_hi), .cfg_inv_lo(cfg_inv_lo), .cfg_dead(cfg_dead),
        .raw_hi(raw_hi), .raw_lo(raw_lo), .period_start(period_start),
        .ovr_en(ovr_en), .ovr_hi(ovr_hi), .ovr_lo(ovr_lo),
        .pin_hi(pin_hi), .pin_lo(pin_lo), .own_hi(own_hi), .own_lo(own_lo)
    );

    always #2 clk = ~clk;   // 250 MHz

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // bench reference state
    logic [1:0] m_mode = 0;
    logic m_swap = 0, m_force = 0, m_enh = 0, m_enl = 0, m_invh = 0, m_invl = 0;
    int   m_dead = 0;
    logic m_lvl = 0;
    logic m_side = 1;
    int   m_cnt = 0;
    logic exp_ph = 0, exp_pl = 0, exp_oh = 0, exp_ol = 0;

    task automatic check(input string tag);
        n_vec++;
        if (pin_hi !== exp_ph || pin_lo !== exp_pl || own_hi !== exp_oh || own_lo !== exp_ol) begin
            n_bad++;
            $display("FAIL %s @%0t: got pin_hi=%0b pin_lo=%0b own_hi=%0b own_lo=%0b, expected %0b %0b %0b %0b",
                     tag, $time, pin_hi, pin_lo, own_hi, own_lo, exp_ph, exp_pl, exp_oh, exp_ol);
        end
    endtask

    // one clock edge of the requirement-level reference
    task automatic model_step();
        logic t, lh, ll, sh, sl;
        t  = ovr_en ? ovr_hi : raw_hi;
        lh = 0;
        ll = 0;
        if (period_start) m_side = ~m_side;
        if (m_mode == 2'b00) begin
            if (ovr_en && m_force) begin
                m_lvl = t; m_cnt = 0;
            end else if (t != m_lvl) begin
                m_lvl = t; m_cnt = m_dead;
            end else if (m_cnt != 0) begin
                m_cnt = m_cnt - 1;
            end
            if (m_cnt == 0) begin lh = m_lvl; ll = !m_lvl; end
        end else begin
            m_lvl = t;
            m_cnt = 0;
            if (m_mode == 2'b01) begin
                lh = t;
                ll = ovr_en ? ovr_lo : raw_lo;
            end else if (m_mode == 2'b10) begin
                if (ovr_en) begin lh = ovr_hi; ll = ovr_lo; end
                else begin lh = raw_hi & !m_side; ll = raw_hi & m_side; end
            end
        end
        sh = m_swap ? ll : lh;
        sl = m_swap ? lh : ll;
        exp_ph = sh ^ m_invh;
        exp_pl = sl ^ m_invl;
        if (cfg_we) begin
            m_swap  = cfg_swap;
            m_force = cfg_force_on;
            m_dead  = int'(cfg_dead);
            if (!gen_on) begin
                m_mode = cfg_mode;
                m_enh  = cfg_en_hi;  m_enl  = cfg_en_lo;
                m_invh = cfg_inv_hi; m_invl = cfg_inv_lo;
            end
        end
        exp_oh = m_enh;
        exp_ol = m_enl;
    endtask

    task automatic tick(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic write_cfg(input logic [1:0] md, input logic sw, input logic fo,
                             input logic eh, input logic el, input logic ih, input logic il,
                             input int dt, input string tag);
        cfg_we = 1; cfg_mode = md; cfg_swap = sw; cfg_force_on = fo;
        cfg_en_hi = eh; cfg_en_lo = el; cfg_inv_hi = ih; cfg_inv_lo = il;
        cfg_dead = DT_W'(dt);
        tick(tag);
        cfg_we = 0;
    endtask

    function automatic string mode_tag(input logic [1:0] md);
        case (md)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R12 reset");
        rst_n = 1;

        // R12/R4: first push-pull period lands on the high pin
        write_cfg(2'b10, 0, 0, 1, 1, 0, 0, 0, "R10 enable write");
        gen_on = 1;
        raw_hi = 1; period_start = 1; tick("R12 first period high");
        period_start = 0; tick("R4 high pulse held");
        raw_hi = 0; tick("R4 gap");
        raw_hi = 1; period_start = 1; tick("R4 second period low");
        period_start = 0; raw_hi = 0; tick("R4 end");

        // R11: locked write changes swap only
        write_cfg(2'b11, 1, 0, 0, 0, 1, 1, 2, "R11 locked write");
        raw_hi = 1; period_start = 1; tick("R11 swap applied, mode kept");
        raw_hi = 0; period_start = 0; tick("R11 hold");
        gen_on = 0;

        // R1/R2: complementary with a three-cycle gap
        write_cfg(2'b00, 0, 0, 1, 1, 0, 0, 3, "R1 mode write");
        tick("R1 complementary settle");
        raw_hi = 1;
        for (int k = 0; k < 5; k++) tick("R2 rising gap");
        raw_hi = 0; tick("R2 falling gap");
        raw_hi = 1; tick("R2 restart in gap");
        for (int k = 0; k < 4; k++) tick("R2 restart gap");
        write_cfg(2'b00, 0, 0, 1, 1, 0, 0, 0, "R2 zero gap write");
        raw_hi = 0; tick("R2 zero gap");

        // R7: force-on override
        write_cfg(2'b00, 0, 1, 1, 1, 0, 0, 4, "R7 force write");
        ovr_en = 1; ovr_hi = 1; tick("R7 immediate override");
        ovr_hi = 0; tick("R7 immediate override low");
        write_cfg(2'b00, 0, 0, 1, 1, 0, 0, 2, "R7 force clear");
        ovr_hi = 1;
        for (int k = 0; k < 4; k++) tick("R7 override through gap");
        ovr_en = 0; raw_hi = 1; tick("R6 release");

        // R6/R8/R9: independent with swap and polarity
        write_cfg(2'b01, 1, 0, 1, 0, 1, 0, 0, "R9 polarity write");
        raw_hi = 1; raw_lo = 0; tick("R8 swap");
        raw_hi = 0; raw_lo = 1; tick("R9 polarity after swap");
        ovr_en = 1; ovr_hi = 1; ovr_lo = 1; tick("R6 override independent");
        write_cfg(2'b11, 0, 0, 0, 1, 0, 1, 0, "R5 reserved write");
        tick("R5 reserved with override");
        ovr_en = 0;

        // constrained random
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(7) == 0) raw_hi = ~raw_hi;
            if ($urandom_range(7) == 0) raw_lo = ~raw_lo;
            period_start = ($urandom_range(15) == 0);
            if ($urandom_range(31) == 0) ovr_en = ~ovr_en;
            if ($urandom_range(5) == 0) begin ovr_hi = 1'($urandom); ovr_lo = 1'($urandom); end
            if ($urandom_range(63) == 0) gen_on = ~gen_on;
            cfg_we = ($urandom_range(39) == 0);
            if (cfg_we) begin
                cfg_mode = 2'($urandom); cfg_swap = 1'($urandom);
                cfg_force_on = 1'($urandom);
                cfg_en_hi = 1'($urandom); cfg_en_lo = 1'($urandom);
                cfg_inv_hi = 1'($urandom); cfg_inv_lo = 1'($urandom);
                cfg_dead = DT_W'($urandom_range(7));
            end
            tick(mode_tag(m_mode));
        end
        cfg_we = 0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule